// File: doc/BRIEF.md
# Flash Software Identification Mode Controller

This block sits beside the array of a byte-wide flash memory. It watches the command writes that reach the part and decides whether the part is in software identification mode. A fixed three-write unlock sequence enters the mode. In the mode, reads at address 0 return the maker code and reads at address 1 return the part code. The read path of the chip then takes the override byte from this block instead of array data. The mode is left either by the same unlock prefix ending in the reset byte, or by one write of the reset byte alone.

Command writes arrive as one-cycle strobes with address and data. The block accepts a write on every cycle that the strobe is high, so it never applies back-pressure and has no ready signal. The read side is a combinational lookup from the read address. The ID-mode flag changes one clock after the write that causes the change.

Top module: `flash_id_mode`

## Requirements
- R1: After reset the ID-mode flag is 0, the override read data is 0, and the sequence decoder is idle.
- R2: Three consecutive writes of AAh to 5555h, 55h to 2AAAh and 90h to 5555h set the ID-mode flag. The flag becomes 1 in the cycle after the clock edge that takes the third write.
- R3: While the ID-mode flag is 1, a read at address 0 returns the maker code DAh.
- R4: While the ID-mode flag is 1, a read at address 1 returns the part code 8Ch.
- R5: While the ID-mode flag is 1, a read at any other address returns 0. While the flag is 0, the override read data is always 0.
- R6: Three consecutive writes of AAh to 5555h, 55h to 2AAAh and F0h to 5555h clear the ID-mode flag.
- R7: A single write of F0h to any address clears the ID-mode flag and returns the decoder to idle, whatever step the decoder was at.
- R8: A write that does not match the expected step returns the decoder to idle and leaves the ID-mode flag unchanged, unless its data is F0h. A full three-write sequence is then needed to enter the mode.
- R9: Address and data presented while the write strobe is 0 have no effect on the flag or on the decoder.
- R10: Command addresses are matched on their low 15 bits only, so upper address bits do not affect the unlock sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Command write strobe, one write per high cycle |
| wr_addr | input | ADDR_W | Command write address |
| wr_data | input | DATA_W | Command write data |
| rd_addr | input | ADDR_W | Read address |
| id_active | output | 1 | Identification mode flag |
| id_rdata | output | DATA_W | Override read byte |

## Verification
The bench uses the default parameters: an 18-bit address, a 15-bit command compare and 8-bit data. Because the address is wider than the compare field, the bench can drive unlock writes with upper address bits set and show that they still match. It can also probe read addresses that share low bits with 0 and 1, which must read as 0. A behavioural model of the flag and the decoder step is checked on every clock against the outputs, while streams of complete, broken and reset-byte writes are applied.

// File: rtl/flash_id_pkg.sv
package flash_id_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_KEY1 = 2'd1,
    SEQ_KEY2 = 2'd2
  } seq_state_t;
endpackage

// File: rtl/flash_id_seq.sv
module flash_id_seq
  import flash_id_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int CMD_ADDR_W = 15,
  parameter int DATA_W     = 8,
  parameter logic [CMD_ADDR_W-1:0] UNLOCK_A = 15'h5555,
  parameter logic [CMD_ADDR_W-1:0] UNLOCK_B = 15'h2AAA,
  parameter logic [DATA_W-1:0] CODE_KEY1  = 8'hAA,
  parameter logic [DATA_W-1:0] CODE_KEY2  = 8'h55,
  parameter logic [DATA_W-1:0] CODE_ENTER = 8'h90,
  parameter logic [DATA_W-1:0] CODE_EXIT  = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              mode_q
);
  logic [CMD_ADDR_W-1:0] cmd_addr;
  logic                  at_a, at_b, is_exit;
  seq_state_t            state_q, state_d;
  logic                  mode_d;

  assign cmd_addr = wr_addr[CMD_ADDR_W-1:0];
  assign at_a     = (cmd_addr == UNLOCK_A);
  assign at_b     = (cmd_addr == UNLOCK_B);
  assign is_exit  = (wr_data == CODE_EXIT);

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    if (wr_en) begin
      state_d = SEQ_IDLE;
      if (is_exit) begin
        mode_d = 1'b0;
      end else begin
        unique case (state_q)
          SEQ_IDLE: if (at_a && wr_data == CODE_KEY1) state_d = SEQ_KEY1;
          SEQ_KEY1: if (at_b && wr_data == CODE_KEY2) state_d = SEQ_KEY2;
          SEQ_KEY2: if (at_a && wr_data == CODE_ENTER) mode_d = 1'b1;
          default:  state_d = SEQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      mode_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
    end
  end
endmodule

// File: rtl/flash_id_rdmux.sv
module flash_id_rdmux #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8,
  parameter int N_ID   = 2,
  parameter logic [N_ID*DATA_W-1:0] ID_TABLE = 16'h8C_DA
) (
  input  logic              mode,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rdata
);
  logic [N_ID-1:0]   hit;
  logic [DATA_W-1:0] slot [N_ID];

  for (genvar g = 0; g < N_ID; g++) begin : g_slot
    assign hit[g]  = mode && (rd_addr == ADDR_W'(g));
    assign slot[g] = hit[g] ? ID_TABLE[g*DATA_W +: DATA_W] : '0;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_ID; i++) rdata = rdata | slot[i];
  end
endmodule

// File: rtl/flash_id_mode.sv
module flash_id_mode #(
  parameter int ADDR_W     = 18,
  parameter int CMD_ADDR_W = 15,
  parameter int DATA_W     = 8,
  parameter logic [DATA_W-1:0] MAKER_CODE = 8'hDA,
  parameter logic [DATA_W-1:0] PART_CODE  = 8'h8C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              id_active,
  output logic [DATA_W-1:0] id_rdata
);
  localparam int N_ID = 2;
  localparam logic [N_ID*DATA_W-1:0] ID_TABLE = {PART_CODE, MAKER_CODE};

  logic mode;

  flash_id_seq #(
    .ADDR_W(ADDR_W), .CMD_ADDR_W(CMD_ADDR_W), .DATA_W(DATA_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .mode_q(mode)
  );

  flash_id_rdmux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_ID(N_ID), .ID_TABLE(ID_TABLE)
  ) u_rdmux (
    .mode(mode), .rd_addr(rd_addr), .rdata(id_rdata)
  );

  assign id_active = mode;
endmodule

// File: rtl/flash_id_mode_chk.sv
module flash_id_mode_chk #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] MAKER_CODE = 8'hDA,
  parameter logic [DATA_W-1:0] PART_CODE  = 8'h8C
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              id_active,
  input logic [DATA_W-1:0] id_rdata
);
  // R2
  enter_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_active) |-> $past(wr_en && wr_data == 8'h90));
  // R7
  exit_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == 8'hF0) |=> !id_active);
  // R9
  idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(id_active));
  // R5
  quiet_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !id_active |-> id_rdata == '0);
  // R3
  maker_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_active && rd_addr == '0) |-> id_rdata == MAKER_CODE);
  // R4
  part_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_active && rd_addr == ADDR_W'(1)) |-> id_rdata == PART_CODE);
endmodule

bind flash_id_mode flash_id_mode_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAKER_CODE(MAKER_CODE), .PART_CODE(PART_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_addr(rd_addr), .id_active(id_active), .id_rdata(id_rdata)
);

// File: tb/flash_id_mode_tb.sv
module flash_id_mode_tb;
  localparam int AW = 18;
  localparam int DW = 8;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          wr_en = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic          id_active;
  logic [DW-1:0] id_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int m_step = 0;
  bit m_mode = 0;

  always #2 clk = ~clk;

  flash_id_mode u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .id_active(id_active), .id_rdata(id_rdata)
  );

  function automatic logic [DW-1:0] exp_read(bit mode, logic [AW-1:0] a);
    if (!mode) return '0;
    if (a == 0) return 8'hDA;
    if (a == 1) return 8'h8C;
    return '0;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // model update and per-clock comparison
  always @(posedge clk) begin
    if (rst_n && !done) begin
      if (wr_en) begin
        logic [14:0] ca;
        ca = wr_addr[14:0];
        if (wr_data == 8'hF0) begin
          m_mode = 0; m_step = 0;
        end else if (m_step == 0 && ca == 15'h5555 && wr_data == 8'hAA) m_step = 1;
        else if (m_step == 1 && ca == 15'h2AAA && wr_data == 8'h55) m_step = 2;
        else if (m_step == 2 && ca == 15'h5555 && wr_data == 8'h90) begin
          m_mode = 1; m_step = 0;
        end else m_step = 0;
      end
      #1;
      check("R2 R6 R7 R8 model flag", id_active, m_mode);
      check("R5 model read", id_rdata, exp_read(m_mode, rd_addr));
    end
  end

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_addr = $urandom; wr_data = $urandom;
  endtask

  task automatic enter(logic [AW-1:0] hi);
    wr(hi | 18'h05555, 8'hAA);
    wr(hi | 18'h02AAA, 8'h55);
    wr(hi | 18'h05555, 8'h90);
  endtask

  task automatic rd(logic [AW-1:0] a, int exp, string tag);
    @(negedge clk);
    rd_addr = a;
    #1;
    check(tag, id_rdata, exp);
  endtask

  task automatic flag(int exp, string tag);
    @(negedge clk);
    #1;
    check(tag, id_active, exp);
  endtask

  initial begin
    #200_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 flag", id_active, 0);
    check("R1 rdata", id_rdata, 0);
    rst_n = 1;
    rd(0, 0, "R5 addr0 outside mode");

    // R2 entry, flag visible after third write
    enter('0);
    flag(1, "R2 entered");
    rd(0, 8'hDA, "R3 maker code");
    rd(1, 8'h8C, "R4 part code");
    rd(2, 0, "R5 addr2");
    rd(18'h10000, 0, "R5 high alias of 0");
    rd(18'h3FFFF, 0, "R5 top addr");

    // R9 writes with strobe low ignored
    @(negedge clk); wr_addr = 18'h1234; wr_data = 8'hF0;
    repeat (3) @(negedge clk);
    flag(1, "R9 strobe low ignored");

    // R6 three-cycle exit
    wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, 8'hF0);
    flag(0, "R6 three-cycle exit");
    rd(0, 0, "R5 addr0 after exit");

    // R8 broken sequence, no entry
    wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55); wr(18'h05555, 8'h80);
    flag(0, "R8 broken step3");
    wr(18'h05555, 8'h90);
    flag(0, "R8 no carry-over");
    wr(18'h05555, 8'hAA); wr(18'h02AAB, 8'h55); wr(18'h05555, 8'h90);
    flag(0, "R8 wrong addr step2");

    // R10 upper address bits ignored
    enter(18'h28000);
    flag(1, "R10 upper bits ignored");

    // R8 broken sequence in mode keeps the mode
    wr(18'h05555, 8'hAA); wr(18'h00000, 8'h12);
    flag(1, "R8 mode kept");

    // R7 single F0 anywhere
    wr(18'h3ABCD, 8'hF0);
    flag(0, "R7 single exit");

    // R7 F0 mid-sequence resets decoder
    enter('0);
    wr(18'h05555, 8'hAA); wr(18'h00007, 8'hF0); wr(18'h05555, 8'h90);
    flag(0, "R7 mid-sequence exit");

    // R9 pulses between steps still count
    wr(18'h05555, 8'hAA);
    repeat (4) @(negedge clk);
    wr(18'h02AAA, 8'h55); wr(18'h05555, 8'h90);
    flag(1, "R9 gaps between writes");
    rd(1, 8'h8C, "R4 part code again");

    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule